// File: doc/BRIEF.md
# Slot-based PCI interrupt router

This block takes an interrupt event from a PCI slot, given as a slot number and an interrupt pin (INTA to INTD encoded 0 to 3). It translates the pair into an interrupt number of the bridge, using a fixed and irregular slot table. Numbers from 32 upward name the bridge's internal lines. The internal line index is the number minus 32.

For a line inside the 32-line window, the event drives a single registered CPU interrupt output. Two 32-bit configuration words select the shape per line. An edge bit that is set produces a one-cycle pulse. When the edge bit is clear, the output takes and holds a level equal to the line's polarity bit.

The mapped number is shown combinationally on its own output, so the routing can be observed without an event. An event whose number falls outside the window leaves the CPU output as it was.

Top module: `irq_router`

## Requirements
- R1: For slot 5, pin p gives interrupt number 32 + (p mod 4) on `irq_num_o`, in the same cycle.
- R2: Slot 6 gives number 36 for every pin, and slot 7 gives 37 for every pin.
- R3: For slots 8 through 12, pin p gives number (slot - 8 + p) + 38.
- R4: Any slot other than 5 to 12 gives a number equal to the pin value (0 to 3). That number lies below 32, so the line is outside the window.
- R5: An event on line L (number minus 32) with bit L of `edge_cfg_i` set drives `cpu_irq_o` high in the cycle after the strobe. If no new event arrives, the output is low again one cycle later.
- R6: An event on line L with bit L of `edge_cfg_i` clear sets `cpu_irq_o`, from the next cycle, to bit L of `pol_cfg_i`. The output holds that value while no further event arrives.
- R7: An event whose number minus 32 lies outside 0..31 has no effect on `cpu_irq_o`, whatever the configuration words hold.
- R8: While `rst_n` is low, and in the first cycle after reset, `cpu_irq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_i | input | 5 | Slot number of the requesting device |
| pin_i | input | 2 | Interrupt pin, 0..3 for INTA..INTD |
| evt_i | input | 1 | One-cycle event strobe for the slot and pin |
| edge_cfg_i | input | 32 | Per-line select: 1 = pulse, 0 = level |
| pol_cfg_i | input | 32 | Per-line level driven when the edge bit is clear |
| irq_num_o | output | 8 | Mapped interrupt number, combinational |
| cpu_irq_o | output | 1 | Registered CPU interrupt output |

## Verification
The bench sweeps every slot and pin pair through the table. This catches a rotation that is off by one in slots 8 to 12, and a slot-5 modulo applied to the wrong operand. It also catches slots 6 and 7 swapped or falling through to pass-through.

Each in-window line is then fired with its edge bit both set and clear, under two complementary polarity patterns. A shaper that indexes the wrong bit, or leaves the pulse stuck high, shows up as a wrong level one or two cycles after the strobe. Events from out-of-range slots, fired with every edge bit set, catch a decoder that wraps the negative line index back into the window and disturbs the held level.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  parameter int SLOT_W      = 5;
  parameter int PIN_W       = 2;
  parameter int NUM_W       = 8;
  parameter int IRQ_BASE    = 32;
  parameter int PIN_COUNT   = 4;
  parameter int MOD_SLOT    = 5;
  parameter int FIX_SLOT_A  = 6;
  parameter int FIX_LINE_A  = 4;
  parameter int FIX_SLOT_B  = 7;
  parameter int FIX_LINE_B  = 5;
  parameter int ROT_FIRST   = 8;
  parameter int ROT_LAST    = 12;
  parameter int ROT_OFFSET  = 6;

  typedef logic [SLOT_W-1:0] slot_t;
  typedef logic [PIN_W-1:0]  pin_t;
  typedef logic [NUM_W-1:0]  num_t;

  // Slot table: modulo slot, two fixed slots, a rotating range, pass-through.
  function automatic num_t route_slot(slot_t s, pin_t p);
    int unsigned si;
    int unsigned pi;
    int unsigned r;
    si = int'(s);
    pi = int'(p);
    if (si == MOD_SLOT)
      r = (pi % PIN_COUNT) + IRQ_BASE;
    else if (si == FIX_SLOT_A)
      r = FIX_LINE_A + IRQ_BASE;
    else if (si == FIX_SLOT_B)
      r = FIX_LINE_B + IRQ_BASE;
    else if (si >= ROT_FIRST && si <= ROT_LAST)
      r = (si - ROT_FIRST + pi) + ROT_OFFSET + IRQ_BASE;
    else
      r = pi;
    return num_t'(r);
  endfunction

  // True when the number falls inside the window of internal lines.
  function automatic logic line_in_window(num_t n, int lines);
    return (int'(n) >= IRQ_BASE) && (int'(n) - IRQ_BASE < lines);
  endfunction
endpackage

// File: rtl/irq_slot_map.sv
module irq_slot_map
  import irq_route_pkg::*;
(
  input  slot_t slot_i,
  input  pin_t  pin_i,
  output num_t  num_o
);
  assign num_o = route_slot(slot_i, pin_i);
endmodule

// File: rtl/irq_line_decode.sv
module irq_line_decode
  import irq_route_pkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter int IDX_W     = $clog2(NUM_LINES)
) (
  input  num_t             num_i,
  output logic             ok_o,
  output logic [IDX_W-1:0] idx_o
);
  assign ok_o  = line_in_window(num_i, NUM_LINES);
  assign idx_o = IDX_W'(int'(num_i) - IRQ_BASE);
endmodule

// File: rtl/irq_out_shaper.sv
module irq_out_shaper #(
  parameter int NUM_LINES = 32,
  parameter int IDX_W     = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 evt_i,
  input  logic                 ok_i,
  input  logic [IDX_W-1:0]     idx_i,
  input  logic [NUM_LINES-1:0] edge_cfg_i,
  input  logic [NUM_LINES-1:0] pol_cfg_i,
  output logic                 irq_o
);
  logic evt_valid;
  logic edge_bit;
  logic pol_bit;
  logic pulse_q;
  logic irq_q;

  assign evt_valid = evt_i & ok_i;
  assign edge_bit  = edge_cfg_i[idx_i];
  assign pol_bit   = pol_cfg_i[idx_i];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else if (evt_valid) begin
      if (edge_bit) begin
        irq_q   <= 1'b1;
        pulse_q <= 1'b1;
      end else begin
        irq_q   <= pol_bit;
        pulse_q <= 1'b0;
      end
    end else if (pulse_q) begin
      irq_q   <= 1'b0;
      pulse_q <= 1'b0;
    end
  end

  assign irq_o = irq_q;

  a_r5_pulse_rise: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid && edge_bit |=> irq_o);
  a_r5_pulse_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && edge_bit) ##1 !evt_valid |=> !irq_o);
  a_r6_level_follow: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid && !edge_bit |=> irq_o == $past(pol_bit));
  a_r7_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_valid && !pulse_q |=> $stable(irq_o));
  a_r8_reset_low: assert property (@(posedge clk)
    !rst_n |=> !irq_o);
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_route_pkg::*;
#(
  parameter int NUM_LINES = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [SLOT_W-1:0]    slot_i,
  input  logic [PIN_W-1:0]     pin_i,
  input  logic                 evt_i,
  input  logic [NUM_LINES-1:0] edge_cfg_i,
  input  logic [NUM_LINES-1:0] pol_cfg_i,
  output logic [NUM_W-1:0]     irq_num_o,
  output logic                 cpu_irq_o
);
  localparam int IDX_W = $clog2(NUM_LINES);

  num_t             mapped_num;
  logic             line_ok;
  logic [IDX_W-1:0] line_idx;

  irq_slot_map u_map (
    .slot_i (slot_i),
    .pin_i  (pin_i),
    .num_o  (mapped_num)
  );

  irq_line_decode #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_dec (
    .num_i (mapped_num),
    .ok_o  (line_ok),
    .idx_o (line_idx)
  );

  irq_out_shaper #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_shape (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_i      (evt_i),
    .ok_i       (line_ok),
    .idx_i      (line_idx),
    .edge_cfg_i (edge_cfg_i),
    .pol_cfg_i  (pol_cfg_i),
    .irq_o      (cpu_irq_o)
  );

  assign irq_num_o = mapped_num;

  a_r2_fixed_slots: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(slot_i) == FIX_SLOT_A) |-> (int'(irq_num_o) == IRQ_BASE + FIX_LINE_A));
  a_r4_outside_window: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(slot_i) < MOD_SLOT || int'(slot_i) > ROT_LAST) |-> !line_ok);
endmodule

// File: tb/test_irq_router.sv
module test_irq_router;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  slot_i = '0;
  logic [1:0]  pin_i = '0;
  logic        evt_i = 1'b0;
  logic [31:0] edge_cfg_i = '0;
  logic [31:0] pol_cfg_i = '0;
  logic [7:0]  irq_num_o;
  logic        cpu_irq_o;

  int checks = 0;
  int fails = 0;
  logic exp_lvl = 1'b0;

  always #10 clk = ~clk;

  irq_router i_irq_router (
    .clk(clk), .rst_n(rst_n), .slot_i(slot_i), .pin_i(pin_i), .evt_i(evt_i),
    .edge_cfg_i(edge_cfg_i), .pol_cfg_i(pol_cfg_i),
    .irq_num_o(irq_num_o), .cpu_irq_o(cpu_irq_o)
  );

  function automatic int expect_num(int s, int p);
    if (s == 5) return 32 + p;
    if (s == 6 || s == 7) return s + 30;
    if (s >= 8 && s <= 12) return s + p + 30;
    return p;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic fire(int s, int p);
    @(negedge clk);
    slot_i = 5'(s); pin_i = 2'(p); evt_i = 1'b1;
    @(negedge clk);
    evt_i = 1'b0;
  endtask

  // Fires an in-window event and checks the shaped output over two cycles.
  task automatic shaped(int s, int p);
    int line;
    line = expect_num(s, p) - 32;
    fire(s, p);
    if (edge_cfg_i[line]) begin
      check("R5 pulse high", int'(cpu_irq_o), 1);
      @(negedge clk);
      check("R5 pulse low", int'(cpu_irq_o), 0);
      exp_lvl = 1'b0;
    end else begin
      exp_lvl = pol_cfg_i[line];
      check("R6 level", int'(cpu_irq_o), int'(exp_lvl));
      @(negedge clk);
      check("R6 level held", int'(cpu_irq_o), int'(exp_lvl));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R8 reset low", int'(cpu_irq_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 after reset", int'(cpu_irq_o), 0);

    // R1 R2 R3 R4: full table sweep
    for (int s = 0; s < 32; s++)
      for (int p = 0; p < 4; p++) begin
        slot_i = 5'(s); pin_i = 2'(p);
        #1;
        if (s == 5) check("R1 map", int'(irq_num_o), expect_num(s, p));
        else if (s == 6 || s == 7) check("R2 map", int'(irq_num_o), expect_num(s, p));
        else if (s >= 8 && s <= 12) check("R3 map", int'(irq_num_o), expect_num(s, p));
        else check("R4 map", int'(irq_num_o), expect_num(s, p));
      end

    // R5 R6: shaping over several configuration patterns
    for (int pat = 0; pat < 4; pat++) begin
      edge_cfg_i = (pat < 2) ? 32'h0000_2A55 : 32'h0000_15AA;
      pol_cfg_i  = (pat % 2 == 0) ? 32'h0000_3399 : 32'h0000_0C66;
      if (pat == 0) edge_cfg_i = 32'h0;
      for (int s = 5; s <= 12; s++)
        for (int p = 0; p < 4; p++)
          shaped(s, p);
    end

    // R7: out-of-window events leave the held level alone
    edge_cfg_i = 32'hFFFF_FFFF;
    pol_cfg_i  = 32'hFFFF_FFFF;
    for (int lvl = 0; lvl < 2; lvl++) begin
      edge_cfg_i = 32'h0;
      pol_cfg_i  = (lvl == 1) ? 32'hFFFF_FFFF : 32'h0;
      shaped(6, 0);
      edge_cfg_i = 32'hFFFF_FFFF;
      pol_cfg_i  = ~pol_cfg_i;
      for (int s = 0; s < 32; s++)
        if (s < 5 || s > 12)
          for (int p = 0; p < 4; p++) begin
            fire(s, p);
            check("R7 ignored", int'(cpu_irq_o), int'(exp_lvl));
          end
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule